// File: doc/BRIEF.md
# Cache Tag-Array Maintenance Port

This block gives privileged software direct load/store access to the tag array of a 4-way set-associative cache. A 32-bit access address is decoded into a window select, an entry index, a way number and an associative-enable flag. Reads return the stored tag, replacement (LRU) bits, dirty flag and valid flag of one entry. Writes are non-associative and overwrite the fields of one entry.

When a write targets an entry that is both valid and dirty, the port first raises a write-back request toward the memory side. The request carries the old tag, the index and the way. It keeps its request input stalled until that request is acknowledged. Only then does it store the new fields. Accesses to the data-array window are only flagged for a neighbouring path. Malformed accesses produce an error strobe and change nothing.

Top module: `cache_tag_port`

## Requirements
- R1: After reset, req_ready_o is 1, rsp_valid_o, err_o and wb_valid_o are 0, and every entry reads back as zero.
- R2: The address top byte selects the window. 0xF0 is the tag array. 0xF1 drives data_sel_o high in the same cycle as the request, with no error, no response and no change to the tag array. Any other top byte is rejected with err_o.
- R3: An access with req_size_i other than 2'b10 (longword), or with req_fetch_i high, gives err_o = 1 for one cycle after acceptance, with no rsp_valid_o and no change to the array.
- R4: A tag-array write with address bit 3 (associative flag) set to 1 is rejected in the same way as R3.
- R5: A tag-array read returns {3'b000, tag[28:10], lru[9:4], 2'b00, u[1], v[0]} of the chosen entry on rsp_rdata_o, with rsp_valid_o high one cycle after acceptance, whatever the value of address bit 3.
- R6: A write to an entry that is not both valid and dirty stores the fields at once. The index is taken from address bits [11:4] and the way from bits [13:12] (00 = way 0 … 11 = way 3). rsp_valid_o pulses one cycle later, and rsp_rdata_o carries the stored word in R5 format.
- R7: Write-data bits 31 to 29 are always stored as zero.
- R8: A write with V (bit 0) = 0 stores U = 0 regardless of write-data bit 1.
- R9: A write to an entry with U = 1 and V = 1 raises wb_valid_o one cycle after acceptance. The request carries the old tag on wb_tag_o (22 bits, top three zero) and the index and way. req_ready_o stays low and the entry keeps its old contents while the request is pending.
- R10: wb_valid_o and its payload hold steady until wb_ready_i is high at a clock edge. At that edge the new fields are committed, and the next cycle shows rsp_valid_o = 1, wb_valid_o = 0 and req_ready_o = 1.
- R11: A write changes only the selected way of the selected index. The other ways of that index are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Access request |
| req_ready_o | output | 1 | Port can accept a request |
| req_write_i | input | 1 | 1 = store, 0 = load |
| req_addr_i | input | 32 | Access address |
| req_wdata_i | input | 32 | Store data: tag, LRU, U, V |
| req_size_i | input | 2 | Access size, 2'b10 = longword |
| req_fetch_i | input | 1 | Access is an instruction fetch |
| data_sel_o | output | 1 | Request targets the data-array window |
| rsp_valid_o | output | 1 | Completion of a read or write |
| rsp_rdata_o | output | 32 | Entry contents in R5 format |
| err_o | output | 1 | Rejected access strobe |
| wb_valid_o | output | 1 | Write-back request pending |
| wb_ready_i | input | 1 | Memory side accepts the write-back |
| wb_tag_o | output | 22 | Tag of the line to write back |
| wb_index_o | output | 8 | Index of the line to write back |
| wb_way_o | output | 2 | Way of the line to write back |

## Verification
A write that lands on a valid, dirty entry must start a write-back, and it must also change that same entry. These two events collide on one index and way. The bench first sets up the line with U = 1 and V = 1, then overwrites it. It holds wb_ready_i low for several cycles and checks that the request payload names the old tag and that no response or commit occurs. It then acknowledges and reads the entry back, expecting the new fields. A companion case writes over a valid but clean line and expects an immediate commit with no write-back.

// File: rtl/cache_tag_pkg.sv
package cache_tag_pkg;
  localparam int unsigned ADDR_W   = 32;
  localparam int unsigned DATA_W   = 32;
  localparam int unsigned NUM_SETS = 256;
  localparam int unsigned NUM_WAYS = 4;
  localparam int unsigned IDX_W    = $clog2(NUM_SETS);
  localparam int unsigned WAY_W    = $clog2(NUM_WAYS);
  localparam int unsigned OFF_W    = 4;            // 16-byte lines
  localparam int unsigned TAG_LO   = 10;
  localparam int unsigned TAG_HI   = 28;           // bits 31:29 forced zero
  localparam int unsigned TAG_W    = TAG_HI - TAG_LO + 1;
  localparam int unsigned LRU_LO   = 4;
  localparam int unsigned LRU_W    = 6;
  localparam int unsigned WB_TAG_W = 22;
  localparam int unsigned ASSOC_BIT = 3;
  localparam logic [7:0]  WIN_TAG  = 8'hF0;
  localparam logic [7:0]  WIN_DATA = 8'hF1;
  localparam logic [1:0]  SIZE_LW  = 2'b10;

  typedef struct packed {
    logic [TAG_W-1:0] tag;
    logic [LRU_W-1:0] lru;
    logic             u;
    logic             v;
  } tag_entry_t;

  typedef enum logic [0:0] {ST_IDLE, ST_WB} ctrl_state_e;

  function automatic tag_entry_t pack_entry(input logic [DATA_W-1:0] d);
    tag_entry_t e;
    e.tag = d[TAG_HI:TAG_LO];
    e.lru = d[LRU_LO+LRU_W-1:LRU_LO];
    e.v   = d[0];
    e.u   = d[1] & d[0];
    return e;
  endfunction

  function automatic logic [DATA_W-1:0] fmt_entry(input tag_entry_t e);
    return {3'b000, e.tag, e.lru, 2'b00, e.u, e.v};
  endfunction
endpackage

// File: rtl/cache_tag_decode.sv
module cache_tag_decode
  import cache_tag_pkg::*;
(
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [1:0]        size_i,
  input  logic              fetch_i,
  input  logic              write_i,
  output logic              win_tag_o,
  output logic              win_data_o,
  output logic              illegal_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic [WAY_W-1:0]  way_o
);
  logic assoc;
  logic bad_form;

  always_comb begin
    win_tag_o  = addr_i[ADDR_W-1 -: 8] == WIN_TAG;
    win_data_o = addr_i[ADDR_W-1 -: 8] == WIN_DATA;
    assoc      = addr_i[ASSOC_BIT];
    idx_o      = addr_i[OFF_W +: IDX_W];
    way_o      = addr_i[OFF_W+IDX_W +: WAY_W];
    bad_form   = (size_i != SIZE_LW) || fetch_i;
    illegal_o  = bad_form || !(win_tag_o || win_data_o)
               || (win_tag_o && write_i && assoc);
  end
endmodule

// File: rtl/cache_tag_ram.sv
module cache_tag_ram
  import cache_tag_pkg::*;
#(
  parameter int unsigned SETS = NUM_SETS,
  parameter int unsigned WAYS = NUM_WAYS,
  localparam int unsigned IW  = $clog2(SETS),
  localparam int unsigned WW  = $clog2(WAYS)
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [IW-1:0] rd_idx_i,
  input  logic [WW-1:0] rd_way_i,
  output tag_entry_t    rd_entry_o,
  input  logic          we_i,
  input  logic [IW-1:0] wr_idx_i,
  input  logic [WW-1:0] wr_way_i,
  input  tag_entry_t    wr_entry_i
);
  tag_entry_t way_rd [WAYS];

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    tag_entry_t mem_q [SETS];
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        for (int s = 0; s < SETS; s++) mem_q[s] <= '0;
      end else if (we_i && wr_way_i == WW'(w)) begin
        mem_q[wr_idx_i] <= wr_entry_i;
      end
    end
    assign way_rd[w] = mem_q[rd_idx_i];
  end

  assign rd_entry_o = way_rd[rd_way_i];
endmodule

// File: rtl/cache_tag_ctrl.sv
module cache_tag_ctrl
  import cache_tag_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_write_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  input  logic              win_tag_i,
  input  logic              win_data_i,
  input  logic              illegal_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [WAY_W-1:0]  way_i,
  input  tag_entry_t        rd_entry_i,
  output logic              we_o,
  output logic [IDX_W-1:0]  wr_idx_o,
  output logic [WAY_W-1:0]  wr_way_o,
  output tag_entry_t        wr_entry_o,
  output logic              req_ready_o,
  output logic              data_sel_o,
  output logic              rsp_valid_o,
  output logic [DATA_W-1:0] rsp_rdata_o,
  output logic              err_o,
  output logic              wb_valid_o,
  input  logic              wb_ready_i,
  output logic [WB_TAG_W-1:0] wb_tag_o,
  output logic [IDX_W-1:0]  wb_index_o,
  output logic [WAY_W-1:0]  wb_way_o
);
  ctrl_state_e state_q, state_d;
  tag_entry_t  new_entry, pend_entry_q;
  logic [IDX_W-1:0] pend_idx_q;
  logic [WAY_W-1:0] pend_way_q;
  logic [TAG_W-1:0] old_tag_q;
  logic accept, tag_ok, is_dirty, wb_done;

  assign req_ready_o = state_q == ST_IDLE;
  assign accept      = req_valid_i && req_ready_o;
  assign tag_ok      = accept && win_tag_i && !illegal_i;
  assign data_sel_o  = req_valid_i && win_data_i && !illegal_i;
  assign new_entry   = pack_entry(req_wdata_i);
  assign is_dirty    = rd_entry_i.u && rd_entry_i.v;
  assign wb_done     = state_q == ST_WB && wb_ready_i;

  always_comb begin
    state_d = state_q;
    if (tag_ok && req_write_i && is_dirty) state_d = ST_WB;
    else if (wb_done)                      state_d = ST_IDLE;
  end

  always_comb begin
    if (state_q == ST_WB) begin
      we_o       = wb_ready_i;
      wr_idx_o   = pend_idx_q;
      wr_way_o   = pend_way_q;
      wr_entry_o = pend_entry_q;
    end else begin
      we_o       = tag_ok && req_write_i && !is_dirty;
      wr_idx_o   = idx_i;
      wr_way_o   = way_i;
      wr_entry_o = new_entry;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= ST_IDLE;
      pend_entry_q <= '0;
      pend_idx_q   <= '0;
      pend_way_q   <= '0;
      old_tag_q    <= '0;
      rsp_valid_o  <= 1'b0;
      rsp_rdata_o  <= '0;
      err_o        <= 1'b0;
    end else begin
      state_q     <= state_d;
      rsp_valid_o <= 1'b0;
      err_o       <= accept && illegal_i;
      if (tag_ok && !req_write_i) begin
        rsp_valid_o <= 1'b1;
        rsp_rdata_o <= fmt_entry(rd_entry_i);
      end else if (tag_ok && req_write_i && !is_dirty) begin
        rsp_valid_o <= 1'b1;
        rsp_rdata_o <= fmt_entry(new_entry);
      end else if (tag_ok && req_write_i) begin
        pend_entry_q <= new_entry;
        pend_idx_q   <= idx_i;
        pend_way_q   <= way_i;
        old_tag_q    <= rd_entry_i.tag;
      end else if (wb_done) begin
        rsp_valid_o <= 1'b1;
        rsp_rdata_o <= fmt_entry(pend_entry_q);
      end
    end
  end

  assign wb_valid_o = state_q == ST_WB;
  assign wb_tag_o   = WB_TAG_W'(old_tag_q);
  assign wb_index_o = pend_idx_q;
  assign wb_way_o   = pend_way_q;
endmodule

// File: rtl/cache_tag_port.sv
module cache_tag_port
  import cache_tag_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        req_valid_i,
  output logic        req_ready_o,
  input  logic        req_write_i,
  input  logic [31:0] req_addr_i,
  input  logic [31:0] req_wdata_i,
  input  logic [1:0]  req_size_i,
  input  logic        req_fetch_i,
  output logic        data_sel_o,
  output logic        rsp_valid_o,
  output logic [31:0] rsp_rdata_o,
  output logic        err_o,
  output logic        wb_valid_o,
  input  logic        wb_ready_i,
  output logic [21:0] wb_tag_o,
  output logic [7:0]  wb_index_o,
  output logic [1:0]  wb_way_o
);
  logic win_tag, win_data, illegal, we;
  logic [IDX_W-1:0] idx, wr_idx;
  logic [WAY_W-1:0] way, wr_way;
  tag_entry_t rd_entry, wr_entry;

  cache_tag_decode u_dec (
    .addr_i(req_addr_i), .size_i(req_size_i), .fetch_i(req_fetch_i),
    .write_i(req_write_i), .win_tag_o(win_tag), .win_data_o(win_data),
    .illegal_o(illegal), .idx_o(idx), .way_o(way)
  );

  cache_tag_ram #(.SETS(NUM_SETS), .WAYS(NUM_WAYS)) u_ram (
    .clk_i, .rst_ni, .rd_idx_i(idx), .rd_way_i(way), .rd_entry_o(rd_entry),
    .we_i(we), .wr_idx_i(wr_idx), .wr_way_i(wr_way), .wr_entry_i(wr_entry)
  );

  cache_tag_ctrl u_ctrl (
    .clk_i, .rst_ni, .req_valid_i, .req_write_i, .req_wdata_i,
    .win_tag_i(win_tag), .win_data_i(win_data), .illegal_i(illegal),
    .idx_i(idx), .way_i(way), .rd_entry_i(rd_entry),
    .we_o(we), .wr_idx_o(wr_idx), .wr_way_o(wr_way), .wr_entry_o(wr_entry),
    .req_ready_o, .data_sel_o, .rsp_valid_o, .rsp_rdata_o, .err_o,
    .wb_valid_o, .wb_ready_i, .wb_tag_o, .wb_index_o, .wb_way_o
  );
endmodule

// File: rtl/cache_tag_port_chk.sv
module cache_tag_port_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        req_ready_o,
  input logic        data_sel_o,
  input logic        rsp_valid_o,
  input logic [31:0] rsp_rdata_o,
  input logic        err_o,
  input logic        wb_valid_o,
  input logic        wb_ready_i,
  input logic [21:0] wb_tag_o,
  input logic [7:0]  wb_index_o,
  input logic [1:0]  wb_way_o
);
  // R3
  err_no_rsp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> !rsp_valid_o);
  // R9
  wb_stall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_valid_o |-> !req_ready_o && !rsp_valid_o);
  // R10
  wb_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_valid_o && !wb_ready_i |=> wb_valid_o && $stable(wb_tag_o)
      && $stable(wb_index_o) && $stable(wb_way_o));
  // R10
  wb_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_valid_o && wb_ready_i |=> rsp_valid_o && !wb_valid_o && req_ready_o);
  // R9
  wb_tag_top_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_valid_o |-> wb_tag_o[21:19] == 3'b000);
  // R7
  tag_top_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> rsp_rdata_o[31:29] == 3'b000);
  // R8
  dirty_needs_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && !rsp_rdata_o[0] |-> !rsp_rdata_o[1]);
  // R2
  data_win_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_sel_o && req_ready_o |=> !err_o && !rsp_valid_o);
endmodule

bind cache_tag_port cache_tag_port_chk u_chk (.*);

// File: tb/cache_tag_port_bench.sv
module cache_tag_port_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0, req_fetch = 1'b0, wb_ready = 1'b0;
  logic [31:0] req_addr = '0, req_wdata = '0;
  logic [1:0]  req_size = 2'b10;
  logic        req_ready, data_sel, rsp_valid, err, wb_valid;
  logic [31:0] rsp_rdata;
  logic [21:0] wb_tag;
  logic [7:0]  wb_index;
  logic [1:0]  wb_way;
  int n_chk = 0, n_bad = 0;
  logic r_rsp, r_err, r_dsel;
  logic [31:0] r_data;

  always #4 clk = ~clk;

  cache_tag_port u_cache_tag_port (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_write_i(req_write), .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .req_size_i(req_size), .req_fetch_i(req_fetch), .data_sel_o(data_sel),
    .rsp_valid_o(rsp_valid), .rsp_rdata_o(rsp_rdata), .err_o(err),
    .wb_valid_o(wb_valid), .wb_ready_i(wb_ready), .wb_tag_o(wb_tag),
    .wb_index_o(wb_index), .wb_way_o(wb_way)
  );

  function automatic logic [31:0] addr_of(logic [7:0] win, logic [1:0] w, logic [7:0] i, logic a);
    return {win, 10'd0, w, i, a, 3'd0};
  endfunction

  function automatic logic [31:0] expect_word(logic [31:0] d);
    return {3'b000, d[28:10], d[9:4], 2'b00, d[1] & d[0], d[0]};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic access(logic w, logic [31:0] a, logic [31:0] d, logic [1:0] sz, logic f);
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
    req_size = sz; req_fetch = f;
    #1 r_dsel = data_sel;
    @(negedge clk);
    req_valid = 1'b0; req_size = 2'b10; req_fetch = 1'b0;
    r_rsp = rsp_valid; r_err = err; r_data = rsp_rdata;
  endtask

  task automatic rd(logic [1:0] w, logic [7:0] i, logic a);
    access(1'b0, addr_of(8'hF0, w, i, a), '0, 2'b10, 1'b0);
  endtask

  task automatic t_reset;
    check("R1 ready", 32'(req_ready), 1);
    check("R1 idle outputs", {rsp_valid, err, wb_valid}, 0);
    rd(2'd2, 8'h05, 1'b0);
    check("R1 entry zero", r_data, 0);
    check("R1 rsp", 32'(r_rsp), 1);
  endtask

  task automatic t_write_read;
    logic [31:0] d = (32'h12345 << 10) | (32'h2A << 4) | 32'h1;
    access(1'b1, addr_of(8'hF0, 2'd1, 8'h23, 1'b0), d, 2'b10, 1'b0);
    check("R6 write rsp", {r_rsp, r_err}, 2'b10);
    check("R6 write echo", r_data, expect_word(d));
    rd(2'd1, 8'h23, 1'b0);
    check("R5 read fields", r_data, expect_word(d));
    rd(2'd1, 8'h23, 1'b1);
    check("R5 read ignores A", r_data, expect_word(d));
    rd(2'd0, 8'h23, 1'b0);
    check("R11 way0 untouched", r_data, 0);
    rd(2'd3, 8'h23, 1'b0);
    check("R11 way3 untouched", r_data, 0);
    rd(2'd1, 8'h22, 1'b0);
    check("R6 neighbour index untouched", r_data, 0);
  endtask

  task automatic t_fields;
    access(1'b1, addr_of(8'hF0, 2'd3, 8'hFF, 1'b0), 32'hFFFF_FFF3, 2'b10, 1'b0);
    rd(2'd3, 8'hFF, 1'b0);
    check("R7 top tag bits zero", r_data, 32'h1FFF_FFF3);
    access(1'b1, addr_of(8'hF0, 2'd0, 8'h40, 1'b0), 32'h0000_0402, 2'b10, 1'b0);
    rd(2'd0, 8'h40, 1'b0);
    check("R8 V0 clears U", r_data, 32'h0000_0400);
  endtask

  task automatic t_reject;
    access(1'b1, addr_of(8'hF0, 2'd2, 8'h10, 1'b0), 32'hABCD_0011, 2'b01, 1'b0);
    check("R3 size err", {r_err, r_rsp}, 2'b10);
    access(1'b0, addr_of(8'hF0, 2'd2, 8'h10, 1'b0), '0, 2'b10, 1'b1);
    check("R3 fetch err", {r_err, r_rsp}, 2'b10);
    access(1'b1, addr_of(8'hF0, 2'd2, 8'h10, 1'b1), 32'hABCD_0011, 2'b10, 1'b0);
    check("R4 assoc write err", {r_err, r_rsp}, 2'b10);
    rd(2'd2, 8'h10, 1'b0);
    check("R3 R4 array unchanged", r_data, 0);
  endtask

  task automatic t_windows;
    access(1'b1, addr_of(8'hF1, 2'd2, 8'h10, 1'b0), 32'h0000_5551, 2'b10, 1'b0);
    check("R2 data window strobe", {r_dsel, r_err, r_rsp}, 3'b100);
    access(1'b0, addr_of(8'hE0, 2'd2, 8'h10, 1'b0), '0, 2'b10, 1'b0);
    check("R2 other window err", {r_dsel, r_err, r_rsp}, 3'b010);
    rd(2'd2, 8'h10, 1'b0);
    check("R2 tag array untouched", r_data, 0);
  endtask

  task automatic t_writeback;
    logic [31:0] old_d = (32'h0ABCD << 10) | (32'h15 << 4) | 32'h3;
    logic [31:0] new_d = (32'h00777 << 10) | (32'h07 << 4) | 32'h1;
    logic [31:0] clean = (32'h00111 << 10) | 32'h1;
    // valid but clean line: no write-back
    access(1'b1, addr_of(8'hF0, 2'd1, 8'h23, 1'b0), clean, 2'b10, 1'b0);
    check("R9 clean no wb", {wb_valid, r_rsp}, 2'b01);
    access(1'b1, addr_of(8'hF0, 2'd2, 8'h7E, 1'b0), old_d, 2'b10, 1'b0);
    check("R6 dirty setup", {wb_valid, r_rsp}, 2'b01);
    access(1'b1, addr_of(8'hF0, 2'd2, 8'h7E, 1'b0), new_d, 2'b10, 1'b0);
    check("R9 wb raised", {wb_valid, req_ready, r_rsp}, 3'b100);
    check("R9 wb tag", 32'(wb_tag), 32'h0ABCD);
    check("R9 wb index way", {wb_index, wb_way}, {8'h7E, 2'd2});
    repeat (3) @(negedge clk);
    check("R10 wb held", {wb_valid, req_ready, rsp_valid}, 3'b100);
    check("R10 wb tag held", 32'(wb_tag), 32'h0ABCD);
    wb_ready = 1'b1;
    @(negedge clk);
    wb_ready = 1'b0;
    check("R10 commit rsp", {wb_valid, req_ready, rsp_valid}, 3'b011);
    check("R10 commit echo", rsp_rdata, expect_word(new_d));
    rd(2'd2, 8'h7E, 1'b0);
    check("R10 new fields stored", r_data, expect_word(new_d));
    rd(2'd1, 8'h7E, 1'b0);
    check("R11 sibling way untouched", r_data, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_write_read();
    t_fields();
    t_reject();
    t_windows();
    t_writeback();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule